// File: doc/BRIEF.md
# Addressing and Privilege Mode Controller

This block keeps track of how a processor forms main memory addresses and of whether the current instruction may use privileged operations. It holds one of three addressing modes. In absolute mode the computed address goes to memory as it is. In append mode the address is combined with a segment pointer. In bounded mode the address is relocated against a base register and is always paired with the procedure pointer. For every instruction the block also names the pointer register that supplies the segment part of the address, and it says whether the appending path is used for this reference.

Privilege is not kept in a stored supervisor bit. It is worked out every cycle from three things: the current addressing mode, the privilege bit of the executing segment's descriptor, and the current ring number. A privileged opcode issued without privilege produces a one-cycle illegal-procedure pulse. Reset, faults and interrupts all return the controller to absolute mode. The only way out of absolute mode is a transfer whose operand was fetched through the appending path, or a load of bounded mode.

Top module: `addr_mode_ctrl`

## Requirements
- R1: After reset is released, `mode_o` is 0 (absolute), `priv_o` is 1 and `ill_proc_o` is 0.
- R2: When `trap_i` is high at a clock edge, `mode_o` is 0 (absolute) from the next cycle on, whatever the previous mode.
- R3: Absolute mode is left only by `xfer_i` and `xfer_app_i` both high, which moves to append (`mode_o` = 1). A transfer with `xfer_app_i` low leaves the mode unchanged.
- R4: In append mode, `append_o` is 1. `ptr_sel_o` is 8 (procedure pointer) when `iw_ext_i` = 0, and `{1'b0, iw_ptr_i}` when `iw_ext_i` = 1.
- R5: In absolute mode, `append_o` equals `iw_ext_i`. When `iw_ext_i` = 1, `ptr_sel_o` = `{1'b0, iw_ptr_i}`; when it is 0, `ptr_sel_o` is 8.
- R6: In bounded mode (`mode_o` = 2), `append_o` is 1 and `ptr_sel_o` is 8, regardless of `iw_ext_i` and `iw_ptr_i`.
- R7: `priv_o` is 1 in absolute mode. In append mode it equals `desc_priv_i` AND (`ring_i` == 0). In bounded mode it is 0. It follows its inputs in the same cycle.
- R8: `priv_op_i` high while `priv_o` is 0 gives `ill_proc_o` = 1 for exactly the next cycle. `priv_op_i` high while `priv_o` is 1 gives no pulse.
- R9: `bnd_ld_i` with `bnd_en_i` = 1 enters bounded mode on the next cycle from any mode. `bnd_ld_i` with `bnd_en_i` = 0 moves bounded mode to append and has no effect in the other modes.
- R10: When inputs coincide, `trap_i` wins over `bnd_ld_i`, and `bnd_ld_i` wins over a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trap_i | input | 1 | Fault or interrupt taken this cycle |
| xfer_i | input | 1 | Transfer instruction executed |
| xfer_app_i | input | 1 | The transfer's operand came through the appending path |
| bnd_ld_i | input | 1 | Load of the bounded-mode setting |
| bnd_en_i | input | 1 | Value loaded by `bnd_ld_i`: 1 enter, 0 leave |
| iw_ptr_i | input | 3 | Instruction word pointer-register number (bits 0-2) |
| iw_ext_i | input | 1 | Instruction word pointer-register flag (bit 29) |
| desc_priv_i | input | 1 | Executing segment descriptor marks it privileged |
| ring_i | input | 3 | Current ring number |
| priv_op_i | input | 1 | Current instruction has a privileged opcode |
| mode_o | output | 2 | Addressing mode: 0 absolute, 1 append, 2 bounded |
| ptr_sel_o | output | 4 | Segment source: 0-7 pointer register, 8 procedure pointer |
| append_o | output | 1 | This reference uses the appending path |
| priv_o | output | 1 | Execution is privileged |
| ill_proc_o | output | 1 | Illegal-procedure fault pulse |

## Verification
The three results arrive at different times. Pointer selection, the appending flag and privilege are combinational, so they are due in the same cycle as the instruction bits, descriptor bit and ring that produce them. The mode changes one clock edge after a trap, transfer or bounded load, and the illegal-procedure pulse also appears one edge after the offending opcode. The driver applies each stimulus at a falling edge and queues the expected values: the combinational results for that same cycle, and the mode and fault values that the previous edge should have left behind. The monitor checks them one nanosecond after the same falling edge, so every registered result is compared exactly one edge after its cause.

// File: rtl/amc_pkg.sv
`timescale 1ns/1ps
package amc_pkg;
  typedef enum logic [1:0] {
    AM_ABS = 2'd0,
    AM_APP = 2'd1,
    AM_BND = 2'd2
  } amode_e;
endpackage

// File: rtl/amc_mode_reg.sv
`timescale 1ns/1ps
module amc_mode_reg
  import amc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   trap_i,
  input  logic   xfer_i,
  input  logic   xfer_app_i,
  input  logic   bnd_ld_i,
  input  logic   bnd_en_i,
  output amode_e mode_o
);

  amode_e mode_q;
  amode_e mode_d;
  logic   mode_en;

  // priority: trap, then bounded load, then appended transfer
  always_comb begin
    mode_d = mode_q;
    if (trap_i) begin
      mode_d = AM_ABS;
    end else if (bnd_ld_i) begin
      if (bnd_en_i)
        mode_d = AM_BND;
      else if (mode_q == AM_BND)
        mode_d = AM_APP;
    end else if (xfer_i && xfer_app_i && (mode_q == AM_ABS)) begin
      mode_d = AM_APP;
    end
  end

  assign mode_en = trap_i | bnd_ld_i | xfer_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= AM_ABS;
    else if (mode_en)
      mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R2
  trap_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (mode_q == AM_ABS));

  // R3
  abs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == AM_ABS) && !trap_i && !bnd_ld_i && !(xfer_i && xfer_app_i))
    |=> (mode_q == AM_ABS));

  // R3
  abs_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == AM_ABS) && !trap_i && !bnd_ld_i && xfer_i && xfer_app_i)
    |=> (mode_q == AM_APP));

  // R9
  bnd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_i && bnd_ld_i && bnd_en_i) |=> (mode_q == AM_BND));

  // R10
  bnd_over_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_i && bnd_ld_i && !bnd_en_i && (mode_q == AM_ABS) && xfer_i && xfer_app_i)
    |=> (mode_q == AM_ABS));

endmodule

// File: rtl/amc_ptr_sel.sv
`timescale 1ns/1ps
module amc_ptr_sel
  import amc_pkg::*;
#(
  parameter int NUM_PR = 8,
  localparam int PR_W  = $clog2(NUM_PR),
  localparam int SEL_W = PR_W + 1
) (
  input  amode_e            mode_i,
  input  logic              iw_ext_i,
  input  logic [PR_W-1:0]   iw_ptr_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              app_o
);

  localparam logic [SEL_W-1:0] PPR_CODE = SEL_W'(NUM_PR);

  logic [SEL_W-1:0] pr_code;
  assign pr_code = {1'b0, iw_ptr_i};

  always_comb begin
    sel_o = PPR_CODE;
    app_o = 1'b0;
    unique case (mode_i)
      AM_ABS: begin
        app_o = iw_ext_i;
        if (iw_ext_i) sel_o = pr_code;
      end
      AM_APP: begin
        app_o = 1'b1;
        if (iw_ext_i) sel_o = pr_code;
      end
      AM_BND: begin
        app_o = 1'b1;
      end
      default: begin
        app_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/amc_priv_chk.sv
`timescale 1ns/1ps
module amc_priv_chk
  import amc_pkg::*;
#(
  parameter int RING_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  amode_e            mode_i,
  input  logic              desc_priv_i,
  input  logic [RING_W-1:0] ring_i,
  input  logic              priv_op_i,
  output logic              priv_o,
  output logic              ill_o
);

  logic ring_zero;
  logic ill_q;
  logic ill_d;

  assign ring_zero = (ring_i == '0);

  always_comb begin
    unique case (mode_i)
      AM_ABS:  priv_o = 1'b1;
      AM_APP:  priv_o = desc_priv_i & ring_zero;
      default: priv_o = 1'b0;
    endcase
  end

  assign ill_d = priv_op_i & ~priv_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ill_q <= 1'b0;
    else
      ill_q <= ill_d;
  end

  assign ill_o = ill_q;

  // R7
  abs_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == AM_ABS) |-> priv_o);

  // R7
  bnd_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == AM_BND) |-> !priv_o);

  // R8
  ill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_op_i && !priv_o) |=> ill_o);

  // R8
  ill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(priv_op_i && !priv_o) |=> !ill_o);

endmodule

// File: rtl/addr_mode_ctrl.sv
`timescale 1ns/1ps
module addr_mode_ctrl
  import amc_pkg::*;
#(
  parameter int NUM_PR = 8,
  parameter int RING_W = 3,
  localparam int PR_W  = $clog2(NUM_PR),
  localparam int SEL_W = PR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              xfer_i,
  input  logic              xfer_app_i,
  input  logic              bnd_ld_i,
  input  logic              bnd_en_i,
  input  logic [PR_W-1:0]   iw_ptr_i,
  input  logic              iw_ext_i,
  input  logic              desc_priv_i,
  input  logic [RING_W-1:0] ring_i,
  input  logic              priv_op_i,
  output logic [1:0]        mode_o,
  output logic [SEL_W-1:0]  ptr_sel_o,
  output logic              append_o,
  output logic              priv_o,
  output logic              ill_proc_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  amode_e     mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  amc_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .trap_i     (trap_i),
    .xfer_i     (xfer_i),
    .xfer_app_i (xfer_app_i),
    .bnd_ld_i   (bnd_ld_i),
    .bnd_en_i   (bnd_en_i),
    .mode_o     (mode)
  );

  amc_ptr_sel #(.NUM_PR(NUM_PR)) u_sel (
    .mode_i   (mode),
    .iw_ext_i (iw_ext_i),
    .iw_ptr_i (iw_ptr_i),
    .sel_o    (ptr_sel_o),
    .app_o    (append_o)
  );

  amc_priv_chk #(.RING_W(RING_W)) u_priv (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mode_i      (mode),
    .desc_priv_i (desc_priv_i),
    .ring_i      (ring_i),
    .priv_op_i   (priv_op_i),
    .priv_o      (priv_o),
    .ill_o       (ill_proc_o)
  );

  assign mode_o = mode;

  // R4
  app_pr_sel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mode == AM_APP) && iw_ext_i) |-> (append_o && (ptr_sel_o == {1'b0, iw_ptr_i})));

  // R5
  abs_direct_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mode == AM_ABS) && !iw_ext_i) |-> !append_o);

  // R6
  bnd_ppr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == AM_BND) |-> (append_o && (ptr_sel_o == SEL_W'(NUM_PR))));

endmodule

// File: tb/addr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module addr_mode_ctrl_tb_top;

  typedef struct {
    int    mode;
    int    sel;
    int    app;
    int    priv;
    int    ill;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trap_i, xfer_i, xfer_app_i, bnd_ld_i, bnd_en_i;
  logic [2:0] iw_ptr_i;
  logic       iw_ext_i, desc_priv_i;
  logic [2:0] ring_i;
  logic       priv_op_i;
  logic [1:0] mode_o;
  logic [3:0] ptr_sel_o;
  logic       append_o, priv_o, ill_proc_o;

  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  int   m_mode = 0;
  int   m_ill  = 0;

  always #2.5 clk = ~clk;

  addr_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .xfer_i(xfer_i),
    .xfer_app_i(xfer_app_i), .bnd_ld_i(bnd_ld_i), .bnd_en_i(bnd_en_i),
    .iw_ptr_i(iw_ptr_i), .iw_ext_i(iw_ext_i), .desc_priv_i(desc_priv_i),
    .ring_i(ring_i), .priv_op_i(priv_op_i), .mode_o(mode_o),
    .ptr_sel_o(ptr_sel_o), .append_o(append_o), .priv_o(priv_o),
    .ill_proc_o(ill_proc_o)
  );

  task automatic cmp(string tag, string fld, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expectations
  task automatic step(bit trap, bit xf, bit xa, bit bl, bit be,
                      int ptr, bit ext, bit dp, int ring, bit pop, string tag);
    exp_t e;
    int   pv;
    @(negedge clk);
    trap_i = trap; xfer_i = xf; xfer_app_i = xa; bnd_ld_i = bl; bnd_en_i = be;
    iw_ptr_i = 3'(ptr); iw_ext_i = ext; desc_priv_i = dp; ring_i = 3'(ring);
    priv_op_i = pop;
    pv = (m_mode == 0) ? 1 : (m_mode == 1) ? int'(dp && ring == 0) : 0;
    e.mode = m_mode;
    e.priv = pv;
    e.ill  = m_ill;
    e.app  = (m_mode == 0) ? int'(ext) : 1;
    e.sel  = (m_mode != 2 && ext) ? ptr : 8;
    e.tag  = tag;
    sb_q.push_back(e);
    m_ill = int'(pop && pv == 0);
    if (trap) m_mode = 0;
    else if (bl) begin
      if (be) m_mode = 2;
      else if (m_mode == 2) m_mode = 1;
    end else if (xf && xa && m_mode == 0) m_mode = 1;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.tag, "mode", int'(mode_o), e.mode);
        cmp(e.tag, "sel", int'(ptr_sel_o), e.sel);
        cmp(e.tag, "append", int'(append_o), e.app);
        cmp(e.tag, "priv", int'(priv_o), e.priv);
        cmp(e.tag, "ill", int'(ill_proc_o), e.ill);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    trap_i = 0; xfer_i = 0; xfer_app_i = 0; bnd_ld_i = 0; bnd_en_i = 0;
    iw_ptr_i = 0; iw_ext_i = 0; desc_priv_i = 0; ring_i = 0; priv_op_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 reset state
    idle("R1");
    // R3 transfer without appending keeps absolute
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    idle("R3");
    // R5 absolute mode references
    step(0, 0, 0, 0, 0, 6, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 5, 1, 0, 0, 0, "R5");
    // R8 privileged opcode while privileged: no pulse
    step(0, 0, 0, 0, 0, 0, 0, 0, 3, 1, "R8");
    idle("R8");
    // R3 appended transfer leaves absolute
    step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R4 append mode pointer selection
    step(0, 0, 0, 0, 0, 2, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 3, 1, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 7, 1, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R4");
    // R7 privilege from descriptor and ring
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 7, 0, "R7");
    // R8 illegal procedure pulse then clear
    step(0, 0, 0, 0, 0, 0, 0, 0, 4, 1, "R8");
    idle("R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R8");
    idle("R8");
    // R2 trap from append
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    idle("R2");
    // R9 enter bounded from append
    step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R9");
    // R6 bounded ignores pointer fields; R7 normal in bounded
    step(0, 0, 0, 0, 0, 4, 1, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R6");
    idle("R8");
    // R3 appended transfer in bounded has no effect
    step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R9 leave bounded to append
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
    idle("R9");
    // R9 leave-load in append has no effect
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
    // R10 trap beats bounded load
    step(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R10");
    idle("R10");
    // R9 leave-load in absolute has no effect
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
    // R10 bounded leave-load beats appended transfer
    step(0, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R10");
    // R10 bounded enter-load beats appended transfer
    step(0, 1, 1, 1, 1, 0, 0, 0, 0, 0, "R10");
    // R2 trap from bounded, with a transfer alongside
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    idle("R2");
    // R9 enter bounded directly from absolute
    step(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R9");
    idle("R9");
    idle("R9");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule